// File: doc/BRIEF.md
# Synchronous-Bus Memory Target

This block lets logic on a fast system clock answer as a 256-byte memory (by default) on an 8-bit processor bus. That bus is timed by a single phase clock, Φ2. The bus clock, the read/write line, the 16-bit address and the 8-bit data bus are all oversampled through a synchronizer. The block rebuilds the bus phases from the samples it takes of Φ2. From those phases it produces active-low read and write strobes, and it decides whether the address of the current cycle falls inside its own window.

A read that lands in the window is served from an internal byte array. The array drives the data bus only after Φ2 has risen. It keeps driving until a hold delay has passed after Φ2 falls. A write that lands in the window is committed when Φ2 falls. The value written is the last data sample taken while Φ2 was still high, and the write is only committed if the high phase lasted longer than a setup delay. The address is taken a fixed number of samples into the low phase, after it has had time to settle. The tristate data pins appear as separate output, output-enable and input signals.

The bus has no back-pressure. Each bus cycle is accepted or ignored within that cycle, so the block has no valid/ready interface.

Top module: `syncbus_mem_target`

## Requirements
- R1: `rd_n_o` is low exactly when the synchronized Φ2 sample is high and the synchronized read/write sample is high (high means read). It follows the pins with a latency of two system clocks.
- R2: `wr_n_o` is low exactly when the synchronized Φ2 sample is high and the synchronized read/write sample is low (low means write). Both strobes are high during the Φ2-low phase, and they are never low together.
- R3: The address and direction of a cycle are the pin values present at sample index `ADDR_DLY` of the low phase, where the first low sample has index 0. A low phase with fewer than `ADDR_DLY`+1 samples captures nothing, and the following high phase causes no access.
- R4: For a read whose captured address lies in [`BASE_ADDR`, `BASE_ADDR`+`WIN_BYTES`), `data_oe_o` rises one system clock after `rd_n_o` falls. At that point `data_o` holds the byte stored at offset (address − `BASE_ADDR`).
- R5: Once asserted for a read, `data_oe_o` stays high for the whole high phase. It drops exactly `HOLD_CLKS` system clocks after `rd_n_o` returns high.
- R6: `data_oe_o` never rises for a captured address outside the window or for a write cycle. It is low by the second system clock of any write strobe.
- R7: A write that hits the window stores, at offset (address − `BASE_ADDR`), the data sample taken together with the last high Φ2 sample. Data driven earlier in the same high phase is not stored. Later reads return the stored value.
- R8: A write whose high phase spans `SETUP_CLKS` or fewer system-clock samples is dropped, and the stored byte keeps its previous value.
- R9: A write to an address outside the window changes no stored byte, including the byte whose offset shares the same low address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than Φ2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | Bus clock Φ2 as seen at the pin |
| rw_i | input | 1 | Direction line, high for read, low for write |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Data bus, input side |
| data_o | output | 8 | Data bus, value to drive on reads |
| data_oe_o | output | 1 | Data bus output enable, high to drive |
| rd_n_o | output | 1 | Derived read strobe, active low |
| wr_n_o | output | 1 | Derived write strobe, active low |

## Verification
A wrong phase counter shows up at once as an access that does not happen, or as an output enable that is released a clock early or late after the read strobe rises. The bench compares the enable on every system clock, so such an error is caught on that clock. A wrong captured address, a wrong offset or a write committed from the wrong sample stays hidden in the byte array. It only shows on `data_o` during the next read of that location, so the bench reads back every location it writes and probes alias offsets outside the window. Write cycles with short low phases and short high phases show whether a cycle that should be ignored has changed the stored state.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int BUS_AW = 16;
  localparam int BUS_DW = 8;

  typedef struct packed {
    logic              phi;
    logic              rw;
    logic [BUS_AW-1:0] addr;
    logic [BUS_DW-1:0] data;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);
endpackage

// File: rtl/sbt_sync.sv
module sbt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbt_phase.sv
module sbt_phase #(
  parameter int ADDR_DLY   = 2,
  parameter int SETUP_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phi_s,
  output logic rise,
  output logic fall,
  output logic capture,
  output logic setup_met
);
  localparam int CNT_NEED = (ADDR_DLY > SETUP_CLKS ? ADDR_DLY : SETUP_CLKS) + 1;
  localparam int CNT_W    = $clog2(CNT_NEED + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic             phi_d;
  logic [CNT_W-1:0] lo_cnt;
  logic [CNT_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phi_d  <= 1'b0;
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      phi_d <= phi_s;
      if (phi_s) begin
        lo_cnt <= '0;
        if (hi_cnt != CNT_TOP) hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != CNT_TOP) lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  // lo_cnt counts earlier low samples of the current run; hi_cnt keeps the
  // length of the high run that just ended during the fall cycle.
  assign rise      = phi_s & ~phi_d;
  assign fall      = ~phi_s & phi_d;
  assign capture   = ~phi_s && (lo_cnt == CNT_W'(ADDR_DLY));
  assign setup_met = hi_cnt > CNT_W'(SETUP_CLKS);
endmodule

// File: rtl/sbt_store.sv
module sbt_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/syncbus_mem_target.sv
module syncbus_mem_target
  import sbt_pkg::*;
#(
  parameter logic [BUS_AW-1:0] BASE_ADDR = 16'h0200,
  parameter int WIN_BYTES   = 256,
  parameter int HOLD_CLKS   = 2,
  parameter int SETUP_CLKS  = 2,
  parameter int ADDR_DLY    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2_i,
  input  logic              rw_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [BUS_DW-1:0] data_i,
  output logic [BUS_DW-1:0] data_o,
  output logic              data_oe_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  localparam int OFF_W  = $clog2(WIN_BYTES);
  localparam int HCNT_W = $clog2(HOLD_CLKS + 1);
  localparam logic [BUS_AW:0] WIN_LO = {1'b0, BASE_ADDR};
  localparam logic [BUS_AW:0] WIN_HI = WIN_LO + (BUS_AW+1)'(WIN_BYTES);

  bus_smp_t raw, smp;
  assign raw = '{phi: phi2_i, rw: rw_i, addr: addr_i, data: data_i};

  sbt_sync #(.W(SMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(smp)
  );

  // Strobes derived from the synchronized samples (R1, R2)
  assign rd_n_o = ~(smp.phi & smp.rw);
  assign wr_n_o = ~(smp.phi & ~smp.rw);

  logic rise, fall, capture, setup_met;
  sbt_phase #(.ADDR_DLY(ADDR_DLY), .SETUP_CLKS(SETUP_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .phi_s(smp.phi),
    .rise(rise), .fall(fall), .capture(capture), .setup_met(setup_met)
  );

  // Cycle address and direction, taken inside the low phase (R3)
  logic              cyc_valid, cyc_rw;
  logic [BUS_AW-1:0] cyc_addr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid <= 1'b0;
      cyc_rw    <= 1'b1;
      cyc_addr  <= '0;
    end else if (capture) begin
      cyc_valid <= 1'b1;
      cyc_rw    <= smp.rw;
      cyc_addr  <= smp.addr;
    end else if (fall) begin
      cyc_valid <= 1'b0;
    end
  end

  logic [BUS_AW:0] addr_ext;
  logic            win_hit;
  logic [OFF_W-1:0] cyc_off;
  assign addr_ext = {1'b0, cyc_addr};
  assign win_hit  = cyc_valid && (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
  assign cyc_off  = OFF_W'(cyc_addr - BASE_ADDR);

  // Last data sample of the high phase (R7)
  logic [BUS_DW-1:0] dat_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dat_hi <= '0;
    else if (smp.phi) dat_hi <= smp.data;
  end

  logic rd_hit, commit;
  assign rd_hit = rise && win_hit && cyc_rw;
  assign commit = fall && win_hit && !cyc_rw && setup_met;

  logic [BUS_DW-1:0] rdata;
  sbt_store #(.DEPTH(WIN_BYTES), .DW(BUS_DW)) u_store (
    .clk(clk), .we(commit), .waddr(cyc_off), .wdata(dat_hi),
    .raddr(cyc_off), .rdata(rdata)
  );

  // Output enable: on at a read hit, off HOLD_CLKS after the fall (R4, R5, R6)
  logic [HCNT_W-1:0] hold_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_oe_o <= 1'b0;
      data_o    <= '0;
      hold_cnt  <= '0;
    end else if (rd_hit) begin
      data_oe_o <= 1'b1;
      data_o    <= rdata;
      hold_cnt  <= '0;
    end else if (rise && !smp.rw) begin
      data_oe_o <= 1'b0;
      hold_cnt  <= '0;
    end else if (fall && data_oe_o) begin
      if (HOLD_CLKS <= 1) data_oe_o <= 1'b0;
      else                hold_cnt  <= HCNT_W'(HOLD_CLKS - 1);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == HCNT_W'(1)) data_oe_o <= 1'b0;
    end
  end

  assert_capture_in_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (rd_n_o && wr_n_o));

  assert_oe_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe_o) |-> (!rd_n_o && !$past(rd_n_o) && $past(rd_n_o, 2)));

  assert_no_drive_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n_o && $past(!wr_n_o)) |-> !data_oe_o);

  assert_commit_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (wr_n_o && $past(!wr_n_o)));
endmodule

// File: tb/syncbus_mem_target_bench.sv
module syncbus_mem_target_bench;
  localparam logic [15:0] BASE  = 16'h0200;
  localparam int          WIN   = 256;
  localparam int          HOLD  = 2;
  localparam int          SETUP = 2;
  localparam int          ADLY  = 2;
  localparam int          HD    = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phi2 = 1'b0;
  logic rw = 1'b1;
  logic [15:0] addr = 16'hFFFF;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        oe, rd_n, wr_n;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit started = 1'b0;

  always #5 clk = ~clk;

  syncbus_mem_target #(.BASE_ADDR(BASE), .WIN_BYTES(WIN), .HOLD_CLKS(HOLD),
    .SETUP_CLKS(SETUP), .ADDR_DLY(ADLY), .SYNC_STAGES(2)) u_syncbus_mem_target (
    .clk(clk), .rst_n(rst_n), .phi2_i(phi2), .rw_i(rw), .addr_i(addr),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .rd_n_o(rd_n), .wr_n_o(wr_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Pin history, indexed by the posedge at which a value was sampled
  bit          h_phi [HD];
  bit          h_rw  [HD];
  int          h_addr[HD];
  int          h_data[HD];
  int          n = 0;

  // Behavioural reference state
  int  mem[WIN];
  bit  known[WIN];
  int  lowrun, highrun, last_hi, cap_addr, hold_left, e_dout;
  bit  cap_ok, cap_rw, e_oe, e_rd, e_wr, e_known;

  function automatic bit in_win(input int a);
    return (a >= int'(BASE)) && (a < int'(BASE) + WIN);
  endfunction

  always @(posedge clk) begin
    n++;
    h_phi[n % HD]  = phi2;
    h_rw[n % HD]   = rw;
    h_addr[n % HD] = int'(addr);
    h_data[n % HD] = int'(din);
    if (!rst_n) begin
      lowrun = 0; highrun = 0; last_hi = 0; cap_ok = 0; cap_rw = 1;
      cap_addr = 0; hold_left = 0; e_oe = 0; e_rd = 1; e_wr = 1; e_known = 0;
      for (int i = 0; i < WIN; i++) known[i] = 0;
    end else begin
      bit cphi, pphi, crw, rising, falling;
      int c, p;
      c = (n - 2) % HD; p = (n - 3) % HD;
      cphi = h_phi[c]; pphi = h_phi[p]; crw = h_rw[c];
      rising  = cphi && !pphi;
      falling = !cphi && pphi;
      if (falling) begin
        if (cap_ok && in_win(cap_addr) && !cap_rw && highrun > SETUP) begin
          mem[cap_addr - int'(BASE)] = last_hi;
          known[cap_addr - int'(BASE)] = 1;
        end
        cap_ok = 0;
      end
      if (!cphi && lowrun == ADLY) begin
        cap_ok = 1; cap_addr = h_addr[c]; cap_rw = crw;
      end
      if (rising && cap_ok && in_win(cap_addr) && cap_rw) begin
        e_oe = 1; hold_left = 0;
        e_dout = mem[cap_addr - int'(BASE)];
        e_known = known[cap_addr - int'(BASE)];
      end else if (rising && !crw) begin
        e_oe = 0; hold_left = 0;
      end else if (falling && e_oe) begin
        if (HOLD <= 1) e_oe = 0; else hold_left = HOLD - 1;
      end else if (hold_left > 0) begin
        hold_left--;
        if (hold_left == 0) e_oe = 0;
      end
      if (cphi) begin
        last_hi = h_data[c];
        lowrun = 0;
        if (highrun < 1000) highrun++;
      end else begin
        highrun = 0;
        if (lowrun < 1000) lowrun++;
      end
      e_rd = !(h_phi[(n - 1) % HD] && h_rw[(n - 1) % HD]);
      e_wr = !(h_phi[(n - 1) % HD] && !h_rw[(n - 1) % HD]);
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && started) begin
      chk("R1", "rd_n", int'(rd_n), int'(e_rd));
      chk("R2", "wr_n", int'(wr_n), int'(e_wr));
      chk("R2", "strobes both low", int'(!rd_n && !wr_n), 0);
      chk(tag, "data_oe", int'(oe), int'(e_oe));
      if (e_oe && e_known) chk(tag, "data_out", int'(dout), e_dout);
    end
  end

  // One bus cycle: lo low samples (first carries junk address), hi high samples
  task automatic bus_cyc(input logic [15:0] a, input logic r, input logic [7:0] d,
                         input int lo, input int hi);
    @(negedge clk); phi2 = 1'b0; addr = 16'hFFFF; rw = 1'b1; din = 8'hC3;
    for (int i = 1; i < lo; i++) begin
      @(negedge clk); addr = a; rw = r;
    end
    for (int i = 0; i < hi; i++) begin
      @(negedge clk); phi2 = 1'b1;
      din = r ? 8'hC3 : ((i == hi - 1) ? d : ~d);
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); phi2 = 1'b0; addr = 16'hFFFF; rw = 1'b1;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    chk("R1", "rd_n in reset", int'(rd_n), 1);
    chk("R2", "wr_n in reset", int'(wr_n), 1);
    chk("R6", "data_oe in reset", int'(oe), 0);
    rst_n = 1'b1;
    started = 1'b1;
    idle(6);
    // R6: read outside the window before anything else
    tag = "R6";
    bus_cyc(16'h0100, 1'b1, 8'h00, 6, 4);
    // R7: writes into the window, including both ends
    tag = "R7";
    bus_cyc(16'h0200, 1'b0, 8'h11, 4, 4);
    bus_cyc(16'h0205, 1'b0, 8'h22, 4, 4);
    bus_cyc(16'h02FF, 1'b0, 8'h33, 5, 5);
    // R4 and R5: reads back, various phase lengths
    tag = "R4";
    bus_cyc(16'h0200, 1'b1, 8'h00, 4, 4);
    bus_cyc(16'h0205, 1'b1, 8'h00, 6, 6);
    tag = "R5";
    bus_cyc(16'h02FF, 1'b1, 8'h00, 3, 3);
    bus_cyc(16'h0205, 1'b1, 8'h00, 4, 8);
    // R6: misses just below and just above the window
    tag = "R6";
    bus_cyc(16'h01FF, 1'b1, 8'h00, 4, 4);
    bus_cyc(16'h0300, 1'b1, 8'h00, 4, 4);
    // R9: write that aliases offset 5, then read back offset 5
    tag = "R9";
    bus_cyc(16'h0305, 1'b0, 8'h99, 4, 4);
    bus_cyc(16'h0205, 1'b1, 8'h00, 4, 4);
    // R8: high phase of SETUP samples drops the write, SETUP+1 keeps it
    tag = "R8";
    bus_cyc(16'h0205, 1'b0, 8'hAA, 4, 2);
    bus_cyc(16'h0205, 1'b1, 8'h00, 4, 4);
    bus_cyc(16'h0205, 1'b0, 8'h44, 4, 3);
    bus_cyc(16'h0205, 1'b1, 8'h00, 4, 4);
    // R3: low phase too short to capture an address
    tag = "R3";
    bus_cyc(16'h0200, 1'b1, 8'h00, 2, 4);
    bus_cyc(16'h0200, 1'b0, 8'h77, 2, 4);
    bus_cyc(16'h0200, 1'b1, 8'h00, 3, 4);
    // R7: back-to-back write then read of a new location
    tag = "R7";
    bus_cyc(16'h0280, 1'b0, 8'h5E, 3, 3);
    bus_cyc(16'h0280, 1'b1, 8'h00, 3, 3);
    idle(8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule